// File: doc/BRIEF.md
# Synchronous Serial Absolute Encoder Reader

This block is the master side of a synchronous serial link to an absolute position encoder. On a request it sends a burst of clock pulses to the encoder on its own clock line and takes in one position bit on every rising clock edge, most significant bit first. The frame length is set at run time, up to a parameter limit of 24 bits. When the last bit is in, the word is converted from Gray code to natural binary if the code-select input asks for it. The result is zero-extended to 32 bits and presented as a low and a high 16-bit word, with a one-cycle valid strobe.

Between frames the clock line idles high. It stays high for a programmable recovery time so that the encoder's monoflop can release the latched position before the next burst. The system-clock width of each half period is set by a divider input. A single frame is started by a pulse on the start input. A free-running input keeps frames repeating back to back, each separated by the recovery time.

Top module: `ssi_master`

## Requirements
- R1: After reset the serial clock output is high, both position words are zero and the valid strobe is low.
- R2: A frame starts with a falling edge of the serial clock on the clock edge after a request is seen while idle. It contains exactly as many low pulses as the effective frame length. Each low phase and each in-frame high phase lasts `half_div` system clocks, and a `half_div` of 0 is treated as 1.
- R3: With `gray_sel` = 0 the serial data line is sampled on each rising serial clock edge, and the first bit taken is the most significant bit of the position. Bit k of the result is the bit received k positions before the last one.
- R4: With `gray_sel` = 1 the received word g is converted to binary b by b[n-1] = g[n-1] and b[i] = b[i+1] XOR g[i], where n is the effective frame length.
- R5: Result bits at and above the effective frame length are zero. `pos_lo` carries result bits 15..0 and `pos_hi` carries bits 31..16.
- R6: A `frame_len` of 0, or any value above 24, gives a 24-bit frame.
- R7: `pos_valid` is high for exactly one system clock. It rises one clock after the rising edge that samples the last bit, and the position words change only together with it.
- R8: Between frames the serial clock stays high for at least `half_div` + `gap_ticks` system clocks. When a request is already pending, that high time is exactly `half_div` + `gap_ticks` + 2 clocks.
- R9: While `free_run` is high, frames repeat with no further start pulse. After it drops, no new frame begins once the current one has ended.
- R10: Frame length, code select, divider and recovery time are taken when a frame starts. Changes to those inputs during a frame, and start pulses during a frame, have no effect on that frame and start no extra frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one frame (seen while idle) |
| free_run | input | 1 | Repeat frames continuously while high |
| gray_sel | input | 1 | 1: received word is Gray code, 0: plain binary |
| frame_len | input | 5 | Number of position bits per frame (0 or >24 means 24) |
| half_div | input | 16 | System clocks per serial clock half period (0 means 1) |
| gap_ticks | input | 16 | Recovery time in system clocks after a frame |
| sdata_in | input | 1 | Serial position data from the encoder |
| sclk_out | output | 1 | Serial clock to the encoder, idles high |
| pos_lo | output | 16 | Result bits 15..0 |
| pos_hi | output | 16 | Result bits 31..16 |
| pos_valid | output | 1 | One-cycle strobe when the position words update |

## Verification
The first falling serial clock edge follows the clock edge that sees the request. Each bit is due `half_div` system clocks after its falling edge, and the valid strobe follows exactly one clock after the final rising edge. The bench samples the clock line and the strobe on falling system-clock edges and counts low-phase lengths, pulses and inter-frame high time in those samples. It reads the position words a moment after a rising edge, once the strobe has been seen. The encoder model shifts out a new bit on each falling serial edge. Every frame is compared with the value the model sent, decoded by the rules of the code-select requirement, and a second look after the recovery window confirms that no extra strobe or clock pulse appeared.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2,
      ST_GAP  = 2'd3
   } ssi_state_e;

endpackage

// File: rtl/ssi_timer.sv
module ssi_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/ssi_shreg.sv
module ssi_shreg #(
   parameter int N = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift,
   input  logic         din,
   output logic [N-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clear) begin
         q <= '0;
      end else if (shift) begin
         q <= {q[N-2:0], din};
      end
   end

endmodule

// File: rtl/ssi_decode.sv
module ssi_decode #(
   parameter int N       = 24,
   parameter int OUT_W   = 32,
   parameter int GRAY_EN = 1
) (
   input  logic             gray_sel,
   input  logic [N-1:0]     raw,
   output logic [OUT_W-1:0] word
);

   if (GRAY_EN != 0) begin : g_gray
      logic [N-1:0] bin;
      assign bin[N-1] = raw[N-1];
      for (genvar i = 0; i < N - 1; i++) begin : g_pfx
         assign bin[i] = bin[i+1] ^ raw[i];
      end
      always_comb begin
         word        = '0;
         word[N-1:0] = gray_sel ? bin : raw;
      end
   end else begin : g_bin
      always_comb begin
         word        = '0;
         word[N-1:0] = raw;
      end
   end

endmodule

// File: rtl/ssi_master.sv
module ssi_master #(
   parameter int MAX_BITS = 24,
   parameter int WORD_W   = 16,
   parameter int DIV_W    = 16,
   parameter int GAP_W    = 16,
   parameter int GRAY_EN  = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic                           free_run,
   input  logic                           gray_sel,
   input  logic [$clog2(MAX_BITS+1)-1:0]  frame_len,
   input  logic [DIV_W-1:0]               half_div,
   input  logic [GAP_W-1:0]               gap_ticks,
   input  logic                           sdata_in,
   output logic                           sclk_out,
   output logic [WORD_W-1:0]              pos_lo,
   output logic [WORD_W-1:0]              pos_hi,
   output logic                           pos_valid
);
   import ssi_pkg::*;

   localparam int OUT_W = 2 * WORD_W;
   localparam int LEN_W = $clog2(MAX_BITS + 1);
   localparam int CNT_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;

   if (MAX_BITS < 2 || MAX_BITS > OUT_W) begin : g_bad_bits
      $error("ssi_master: MAX_BITS must lie between 2 and 2*WORD_W");
   end
   if (DIV_W < 1 || GAP_W < 1) begin : g_bad_cnt
      $error("ssi_master: DIV_W and GAP_W must be at least 1");
   end
   if (GRAY_EN != 0 && GRAY_EN != 1) begin : g_bad_gray
      $error("ssi_master: GRAY_EN must be 0 or 1");
   end

   ssi_state_e           state_q;
   logic                 sclk_q;
   logic [LEN_W-1:0]     bits_left_q;
   logic [DIV_W-1:0]     cfg_half_q;
   logic [GAP_W-1:0]     cfg_gap_q;
   logic                 cfg_gray_q;
   logic                 done_q;
   logic [OUT_W-1:0]     pos_q;
   logic                 valid_q;

   logic                 req;
   logic [DIV_W-1:0]     half_eff;
   logic [LEN_W-1:0]     len_eff;
   logic                 tmr_load;
   logic [CNT_W-1:0]     tmr_val;
   logic                 tmr_zero;
   logic                 sh_clear;
   logic                 sh_shift;
   logic [MAX_BITS-1:0]  raw_word;
   logic [OUT_W-1:0]     dec_word;

   assign req      = start | free_run;
   assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
   assign len_eff  = (frame_len == '0 || frame_len > LEN_W'(MAX_BITS)) ?
                     LEN_W'(MAX_BITS) : frame_len;

   // phase timer control and shift strobes
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_clear = 1'b0;
      sh_shift = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(half_eff - DIV_W'(1));
               sh_clear = 1'b1;
            end
         end
         ST_LOW: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(cfg_half_q - DIV_W'(1));
               sh_shift = 1'b1;
            end
         end
         ST_HIGH: begin
            if (tmr_zero) begin
               tmr_load = 1'b1;
               tmr_val  = (bits_left_q == '0) ? CNT_W'(cfg_gap_q) :
                          CNT_W'(cfg_half_q - DIV_W'(1));
            end
         end
         default: begin
         end
      endcase
   end

   // frame sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         sclk_q      <= 1'b1;
         bits_left_q <= '0;
         cfg_half_q  <= DIV_W'(1);
         cfg_gap_q   <= '0;
         cfg_gray_q  <= 1'b0;
         done_q      <= 1'b0;
      end else begin
         done_q <= (state_q == ST_LOW) && tmr_zero && (bits_left_q == LEN_W'(1));
         case (state_q)
            ST_IDLE: begin
               if (req) begin
                  state_q     <= ST_LOW;
                  sclk_q      <= 1'b0;
                  bits_left_q <= len_eff;
                  cfg_half_q  <= half_eff;
                  cfg_gap_q   <= gap_ticks;
                  cfg_gray_q  <= gray_sel;
               end
            end
            ST_LOW: begin
               if (tmr_zero) begin
                  state_q     <= ST_HIGH;
                  sclk_q      <= 1'b1;
                  bits_left_q <= bits_left_q - LEN_W'(1);
               end
            end
            ST_HIGH: begin
               if (tmr_zero) begin
                  if (bits_left_q == '0) begin
                     state_q <= ST_GAP;
                  end else begin
                     state_q <= ST_LOW;
                     sclk_q  <= 1'b0;
                  end
               end
            end
            ST_GAP: begin
               if (tmr_zero) begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // result register and strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= done_q;
         if (done_q) begin
            pos_q <= dec_word;
         end
      end
   end

   ssi_timer #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   ssi_shreg #(.N(MAX_BITS)) u_shreg (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (sh_clear),
      .shift (sh_shift),
      .din   (sdata_in),
      .q     (raw_word)
   );

   ssi_decode #(.N(MAX_BITS), .OUT_W(OUT_W), .GRAY_EN(GRAY_EN)) u_decode (
      .gray_sel (cfg_gray_q),
      .raw      (raw_word),
      .word     (dec_word)
   );

   assign sclk_out  = sclk_q;
   assign pos_lo    = pos_q[WORD_W-1:0];
   assign pos_hi    = pos_q[OUT_W-1:WORD_W];
   assign pos_valid = valid_q;

endmodule

// File: rtl/ssi_master_chk.sv
module ssi_master_chk #(
   parameter int MAX_BITS = 24,
   parameter int WORD_W   = 16,
   parameter int DIV_W    = 16,
   parameter int GAP_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_out,
   input  logic [WORD_W-1:0] pos_lo,
   input  logic [WORD_W-1:0] pos_hi,
   input  logic              pos_valid,
   input  logic [DIV_W-1:0]  cfg_half,
   input  logic [GAP_W-1:0]  cfg_gap
);

   logic [31:0] lo_run;
   logic [31:0] hi_run;
   logic        seen_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_run <= '0;
         hi_run <= '0;
         seen_v <= 1'b0;
      end else begin
         lo_run <= sclk_out ? 32'd0 : lo_run + 32'd1;
         hi_run <= sclk_out ? hi_run + 32'd1 : 32'd0;
         if (pos_valid) begin
            seen_v <= 1'b1;
         end else if (!sclk_out) begin
            seen_v <= 1'b0;
         end
      end
   end

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pos_valid |=> !pos_valid); // R7

   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pos_valid |-> $stable({pos_hi, pos_lo})); // R7

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (({pos_hi, pos_lo}) >> MAX_BITS) == '0); // R5

   AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      lo_run <= 32'(cfg_half)); // R2

   AST_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_v && !sclk_out) |-> (hi_run >= 32'($past(cfg_half)) + 32'($past(cfg_gap)))); // R8

endmodule

bind ssi_master ssi_master_chk #(
   .MAX_BITS (MAX_BITS),
   .WORD_W   (WORD_W),
   .DIV_W    (DIV_W),
   .GAP_W    (GAP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sclk_out  (sclk_out),
   .pos_lo    (pos_lo),
   .pos_hi    (pos_hi),
   .pos_valid (pos_valid),
   .cfg_half  (cfg_half_q),
   .cfg_gap   (cfg_gap_q)
);

// File: tb/sim_ssi_master.sv
`timescale 1ns/1ps
module sim_ssi_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        free_run = 1'b0;
   logic        gray_sel = 1'b0;
   logic [4:0]  frame_len = 5'd24;
   logic [15:0] half_div = 16'd1;
   logic [15:0] gap_ticks = 16'd0;
   logic        sdata = 1'b0;
   logic        sclk_out;
   logic [15:0] pos_lo;
   logic [15:0] pos_hi;
   logic        pos_valid;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ssi_master u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .free_run  (free_run),
      .gray_sel  (gray_sel),
      .frame_len (frame_len),
      .half_div  (half_div),
      .gap_ticks (gap_ticks),
      .sdata_in  (sdata),
      .sclk_out  (sclk_out),
      .pos_lo    (pos_lo),
      .pos_hi    (pos_hi),
      .pos_valid (pos_valid)
   );

   // encoder model: next bit, MSB first, on each falling serial clock edge
   logic [23:0] enc_word = '0;
   int          enc_len = 24;
   int          enc_idx = 0;

   always @(negedge sclk_out) begin
      if (rst_n) begin
         sdata = enc_word[enc_len - 1 - enc_idx];
         enc_idx++;
         if (enc_idx >= enc_len) enc_idx = 0;
      end
   end

   // line monitor, sampled on falling system clock edges
   int  cyc_n = 0;
   int  lo_run = 0;
   int  hi_run = 0;
   int  max_hi = 0;
   int  falls = 0;
   int  bad_low = 0;
   int  h_exp = 1;
   int  rise_cyc = 0;
   int  valid_cyc = 0;
   int  valid_cnt = 0;
   logic prev_sclk = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc_n++;
         if (sclk_out) begin
            if (!prev_sclk) begin
               if (lo_run != h_exp) bad_low++;
               rise_cyc = cyc_n;
            end
            lo_run = 0;
            hi_run++;
         end else begin
            if (prev_sclk) begin
               falls++;
               if (hi_run > max_hi) max_hi = hi_run;
            end
            hi_run = 0;
            lo_run++;
         end
         if (pos_valid) begin
            valid_cnt++;
            valid_cyc = cyc_n;
         end
         prev_sclk = sclk_out;
      end
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", wd);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] to_gray(input logic [23:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [23:0] len_mask(input int n);
      logic [31:0] m;
      m = (32'h1 << n) - 32'h1;
      return m[23:0];
   endfunction

   task automatic wait_valids(input int n);
      int t = 0;
      while (valid_cnt < n && t < 20000) begin
         @(posedge clk);
         #1;
         t++;
      end
      chk(valid_cnt >= n, "R7", "strobe seen", valid_cnt, n);
   endtask

   task automatic run_frame(input int len_set, input int len_eff, input bit gray,
                            input int half, input int gap, input logic [23:0] p,
                            input bit disturb);
      logic [31:0] got;
      @(negedge clk);
      frame_len = 5'(len_set);
      gray_sel  = gray;
      half_div  = 16'(half);
      gap_ticks = 16'(gap);
      h_exp     = (half == 0) ? 1 : half;
      enc_len   = len_eff;
      enc_idx   = 0;
      enc_word  = gray ? to_gray(p) : p;
      falls     = 0;
      bad_low   = 0;
      valid_cnt = 0;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
      if (disturb) begin
         repeat (3) @(negedge clk);
         frame_len = 5'd20;
         gray_sel  = ~gray;
         half_div  = 16'(h_exp + 2);
         gap_ticks = 16'd9;
         start     = 1'b1;
         @(negedge clk);
         start     = 1'b0;
      end
      wait_valids(1);
      got = {pos_hi, pos_lo};
      chk(got == {8'h00, p}, gray ? "R4" : "R3", "position", got, {8'h00, p});
      chk(pos_hi[15:8] == 8'h00, "R5", "upper byte", pos_hi[15:8], 0);
      chk(falls == len_eff, "R2", "clock pulses", falls, len_eff);
      chk(bad_low == 0, "R2", "low phase length errors", bad_low, 0);
      chk(valid_cyc - rise_cyc == 1, "R7", "strobe latency", valid_cyc - rise_cyc, 1);
      repeat (h_exp + gap + 30) @(posedge clk);
      #1;
      chk(valid_cnt == 1, disturb ? "R10" : "R7", "strobe count", valid_cnt, 1);
      chk(falls == len_eff, disturb ? "R10" : "R2", "pulses after frame", falls, len_eff);
      chk({pos_hi, pos_lo} == got, "R7", "word hold", {pos_hi, pos_lo}, got);
   endtask

   initial begin
      void'($urandom(32'h0005_51C0));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(sclk_out == 1'b1, "R1", "sclk after reset", sclk_out, 1);
      chk({pos_hi, pos_lo} == 32'h0, "R1", "position after reset", {pos_hi, pos_lo}, 0);
      chk(pos_valid == 1'b0, "R1", "strobe after reset", pos_valid, 0);

      // directed corner cases
      run_frame(24, 24, 1'b1, 2, 3, 24'h9A5C3E, 1'b0);
      run_frame(24, 24, 1'b0, 1, 0, 24'hFFFFFF, 1'b0);
      run_frame(1,  1,  1'b1, 0, 2, 24'h000001, 1'b0);
      run_frame(13, 13, 1'b0, 3, 1, 24'h001ABC & len_mask(13), 1'b0);
      run_frame(0,  24, 1'b1, 1, 1, 24'h800001, 1'b0);   // R6 zero length
      run_frame(30, 24, 1'b0, 2, 0, 24'h5A5A5A, 1'b0);   // R6 oversize length
      run_frame(12, 12, 1'b1, 2, 2, 24'h000B6D, 1'b1);   // R10 changes mid-frame

      // free-running frames with a measured recovery gap (R8, R9)
      @(negedge clk);
      frame_len = 5'd8;
      gray_sel  = 1'b1;
      half_div  = 16'd2;
      gap_ticks = 16'd3;
      h_exp     = 2;
      enc_len   = 8;
      enc_idx   = 0;
      enc_word  = to_gray(24'h0000C7);
      falls     = 0;
      bad_low   = 0;
      valid_cnt = 0;
      free_run  = 1'b1;
      wait_valids(1);
      max_hi = 0;
      wait_valids(3);
      @(negedge clk);
      free_run = 1'b0;
      chk(max_hi == 2 + 3 + 2, "R8", "inter-frame high time", max_hi, 7);
      chk(falls == 24, "R9", "pulses over three frames", falls, 24);
      chk({pos_hi, pos_lo} == 32'h0000_00C7, "R9", "free-run word", {pos_hi, pos_lo}, 32'hC7);
      repeat (60) @(posedge clk);
      #1;
      chk(falls == 24, "R9", "no frame after free-run drop", falls, 24);
      chk(valid_cnt == 3, "R9", "strobes after drop", valid_cnt, 3);

      // constrained random frames
      for (int k = 0; k < 40; k++) begin
         int          len;
         int          hd;
         int          gp;
         bit          gr;
         logic [23:0] p;
         len = 1 + int'($urandom % 24);
         hd  = int'($urandom % 4);
         gp  = int'($urandom % 6);
         gr  = bit'($urandom % 2);
         p   = $urandom() & len_mask(len);
         run_frame(len, len, gr, hd, gp, p, 1'b0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule